// File: doc/BRIEF.md
# Two-Phase Microcoded Instruction Sequencer

This block is the control unit of a small 4-bit accumulator processor. Each instruction is two program bytes long and takes two clock cycles. A single phase bit alternates between a fetch phase and an execute phase. In the fetch phase the sequencer latches the instruction byte. The upper four bits of that byte are the opcode, which gives sixteen instructions. In the execute phase the second byte is on the program input. Every control signal comes from a lookup table addressed by the opcode, the phase and the carry and zero flags. The table is a parameter, so a new instruction set only needs new table contents.

The sequencer owns the 12-bit program counter. The counter steps once for every byte fetched. A jump loads a 12-bit target formed from the low nibble of the instruction byte and the byte that follows it. The same two fields form the 12-bit address of a 4096 x 4 data RAM. The RAM select is active low and is combined with the clock level, so the RAM can only be selected while the clock is low, which is the second half of each cycle. The RAM write strobe is taken from the table with no gating.

Top module: `nib_seq`

## Requirements
- R1: `rst` is an active-high synchronous reset. A clock edge with `rst` high leaves `phase` at 0 and `prog_addr` at 0. The first fetch after release is from address 0. A reset asserted in the execute phase aborts the instruction.
- R2: When `rst` is low, `phase` inverts on every rising clock edge. Phase 0 is fetch and phase 1 is execute.
- R3: The opcode is `prog_byte[7:4]` in phase 0 and bits 7:4 of the latched instruction byte in phase 1. `uword` is the table entry at index {opcode, phase, carry, zero}, which equals opcode*8 + phase*4 + carry*2 + zero.
- R4: `uword` bit fields: bit 0 latches the instruction byte, bit 1 increments the program counter and bit 2 loads a jump target. When bit 1 is set and bit 2 is clear, `prog_addr` advances by 1 modulo 4096. When neither bit is set, `prog_addr` holds. The default table sets bits 1:0 in every phase-0 entry and bit 1 in every phase-1 entry that is not a taken jump.
- R5: When `uword` bit 2 is set, the next `prog_addr` is {latched byte bits 3:0, current `prog_byte`}. Bit 2 takes priority over bit 1.
- R6: `data_addr` is {latched byte bits 3:0, `prog_byte`}, 12 bits wide.
- R7: `ram_ce_n` is high whenever `clk` is high. While `clk` is low, `ram_ce_n` is low exactly when `uword` bit 10 (RAM request) is set.
- R8: `ram_we_n` is the inverse of `uword` bit 11 and does not depend on the clock. The default table sets bit 11 only together with bit 10.
- R9: Default jumps are JMP=7, JZ=C, JNZ=D, JC=E and JNC=F. In phase 1 a jump sets bit 2 and clears bit 1 when taken, and clears bit 2 and sets bit 1 when not taken. The conditions are: always; zero=1; zero=0; carry=1; carry=0.
- R10: Default data operations in phase 1 use these fields: bit 3 accumulator load, bits 6:5 ALU function (0 pass, 1 add, 2 nor, 3 compare), bits 8:7 bus source (0 none, 1 immediate, 2 RAM, 3 input port). The opcodes are NOP=0, LDI=1, LDM=2, STM=3, ADDI=4, ADDM=5, NORI=6, CMPI=8, CMPM=9, IN=A and OUT=B. RAM opcodes set bit 10, and STM also sets bit 11.
- R11: Replacing the `UCODE` parameter changes the instruction behaviour with no other change. For example, a table where opcode 0 jumps in phase 1 sends `prog_addr` to the jump target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the RAM select is qualified by its level |
| rst | input | 1 | Synchronous active-high reset |
| prog_byte | input | 8 | Program memory byte at `prog_addr` |
| flag_carry | input | 1 | Carry flag from the ALU flag register |
| flag_zero | input | 1 | Zero flag from the ALU flag register |
| prog_addr | output | 12 | Program counter |
| phase | output | 1 | 0 = fetch, 1 = execute |
| uword | output | 12 | Current control word from the table |
| data_addr | output | 12 | Data RAM address |
| ram_ce_n | output | 1 | Active-low RAM select, low only while clk is low |
| ram_we_n | output | 1 | Active-low RAM write strobe |

## Verification
The assertions assume that `prog_byte` and both flags change only while the clock is low and stay stable across each rising edge. They also assume the table never requests a write without a RAM request. The bench drives every input just after a falling edge and uses only the default table and one alternative table that meets this rule. The flags are treated as external inputs with no link to the instruction. This lets the vectors pair each conditional jump with both flag settings, and lets them place a jump at the last program address so that the counter wraps.

// File: rtl/nib_seq_pkg.sv
package nib_seq_pkg;

  localparam int OP_W    = 4;
  localparam int CW_W    = 12;
  localparam int IDX_W   = OP_W + 3;
  localparam int N_WORDS = 1 << IDX_W;

  // control word bit positions
  localparam int B_IR_LD  = 0;
  localparam int B_PC_INC = 1;
  localparam int B_PC_LD  = 2;
  localparam int B_ACC_LD = 3;
  localparam int B_FLG_LD = 4;
  localparam int B_ALU_LO = 5;
  localparam int B_BUS_LO = 7;
  localparam int B_OUT_LD = 9;
  localparam int B_RAM_RQ = 10;
  localparam int B_RAM_WR = 11;

  typedef enum logic [1:0] {ALU_PASS = 2'd0, ALU_ADD = 2'd1, ALU_NOR = 2'd2, ALU_CMP = 2'd3} alu_fn_e;
  typedef enum logic [1:0] {BUS_NONE = 2'd0, BUS_IMM = 2'd1, BUS_RAM = 2'd2, BUS_PORT = 2'd3} bus_src_e;

  function automatic logic [CW_W-1:0] data_op(input alu_fn_e fn, input bus_src_e src,
                                              input logic acc, input logic flg);
    logic [CW_W-1:0] w;
    w = '0;
    w[B_PC_INC] = 1'b1;
    w[B_ACC_LD] = acc;
    w[B_FLG_LD] = flg;
    w[B_ALU_LO +: 2] = fn;
    w[B_BUS_LO +: 2] = src;
    w[B_RAM_RQ] = (src == BUS_RAM);
    return w;
  endfunction

  function automatic logic [CW_W-1:0] jump_op(input logic taken);
    logic [CW_W-1:0] w;
    w = '0;
    w[B_PC_LD]  = taken;
    w[B_PC_INC] = ~taken;
    return w;
  endfunction

  function automatic logic [CW_W-1:0] dflt_word(input logic [OP_W-1:0] op, input logic ph,
                                                input logic cy, input logic zr);
    logic [CW_W-1:0] w;
    w = '0;
    if (!ph) begin
      w[B_IR_LD]  = 1'b1;
      w[B_PC_INC] = 1'b1;
    end else begin
      case (op)
        4'h0: w = data_op(ALU_PASS, BUS_NONE, 1'b0, 1'b0);
        4'h1: w = data_op(ALU_PASS, BUS_IMM,  1'b1, 1'b1);
        4'h2: w = data_op(ALU_PASS, BUS_RAM,  1'b1, 1'b1);
        4'h3: begin
          w = data_op(ALU_PASS, BUS_NONE, 1'b0, 1'b0);
          w[B_RAM_RQ] = 1'b1;
          w[B_RAM_WR] = 1'b1;
        end
        4'h4: w = data_op(ALU_ADD,  BUS_IMM,  1'b1, 1'b1);
        4'h5: w = data_op(ALU_ADD,  BUS_RAM,  1'b1, 1'b1);
        4'h6: w = data_op(ALU_NOR,  BUS_IMM,  1'b1, 1'b1);
        4'h7: w = jump_op(1'b1);
        4'h8: w = data_op(ALU_CMP,  BUS_IMM,  1'b0, 1'b1);
        4'h9: w = data_op(ALU_CMP,  BUS_RAM,  1'b0, 1'b1);
        4'hA: w = data_op(ALU_PASS, BUS_PORT, 1'b1, 1'b1);
        4'hB: begin
          w = data_op(ALU_PASS, BUS_NONE, 1'b0, 1'b0);
          w[B_OUT_LD] = 1'b1;
        end
        4'hC: w = jump_op(zr);
        4'hD: w = jump_op(~zr);
        4'hE: w = jump_op(cy);
        default: w = jump_op(~cy);
      endcase
    end
    return w;
  endfunction

  function automatic logic [N_WORDS*CW_W-1:0] dflt_table();
    logic [N_WORDS*CW_W-1:0] t;
    t = '0;
    for (int i = 0; i < N_WORDS; i++) begin
      logic [IDX_W-1:0] ix;
      ix = IDX_W'(i);
      t[i*CW_W +: CW_W] = dflt_word(ix[IDX_W-1:3], ix[2], ix[1], ix[0]);
    end
    return t;
  endfunction

endpackage

// File: rtl/nib_state.sv
module nib_state #(
  parameter int BYTE_W = 8,
  parameter int OP_W   = 4,
  localparam int LO_W  = BYTE_W - OP_W,
  localparam int PC_W  = LO_W + BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] prog_byte,
  input  logic              ld_ir,
  input  logic              pc_inc,
  input  logic              pc_load,
  output logic              phase,
  output logic [BYTE_W-1:0] ir,
  output logic [PC_W-1:0]   pc
);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      ir    <= '0;
      pc    <= '0;
    end else begin
      phase <= ~phase;
      if (ld_ir) ir <= prog_byte;
      if (pc_load)     pc <= {ir[LO_W-1:0], prog_byte};
      else if (pc_inc) pc <= pc + 1'b1;
    end
  end

  AST_PHASE_FLIPS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> phase != $past(phase)); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (pc_inc && !pc_load) |=> pc == PC_W'($past(pc) + 1'b1)); // R4
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pc_inc && !pc_load) |=> $stable(pc)); // R4
  AST_PC_JUMP: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> pc == {$past(ir[LO_W-1:0]), $past(prog_byte)}); // R5
  AST_IR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    ld_ir |=> ir == $past(prog_byte)); // R4

endmodule

// File: rtl/nib_ucode_rom.sv
module nib_ucode_rom #(
  parameter int OP_W = 4,
  parameter int CW_W = 12,
  localparam int IDX_W   = OP_W + 3,
  localparam int N_WORDS = 1 << IDX_W,
  parameter logic [N_WORDS*CW_W-1:0] UCODE = '0
) (
  input  logic [OP_W-1:0] op,
  input  logic            phase,
  input  logic            carry,
  input  logic            zero,
  output logic [CW_W-1:0] word
);

  logic [CW_W-1:0]  tbl [N_WORDS];
  logic [IDX_W-1:0] idx;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_entry
    assign tbl[g] = UCODE[g*CW_W +: CW_W];
  end

  assign idx  = {op, phase, carry, zero};
  assign word = tbl[idx];

endmodule

// File: rtl/nib_ram_gate.sv
module nib_ram_gate (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic wr,
  output logic ce_n,
  output logic we_n
);

  assign ce_n = ~req | clk;
  assign we_n = ~wr;

  AST_CE_QUIET_HIGH: assert property (@(negedge clk) disable iff (rst)
    !rst |-> ce_n); // R7
  AST_WE_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> req); // R8

endmodule

// File: rtl/nib_seq.sv
module nib_seq #(
  parameter int BYTE_W = 8,
  parameter int OP_W   = nib_seq_pkg::OP_W,
  parameter int CW_W   = nib_seq_pkg::CW_W,
  parameter logic [(1 << (OP_W + 3))*CW_W-1:0] UCODE = nib_seq_pkg::dflt_table()
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [BYTE_W-1:0]                prog_byte,
  input  logic                             flag_carry,
  input  logic                             flag_zero,
  output logic [2*BYTE_W-OP_W-1:0]         prog_addr,
  output logic                             phase,
  output logic [CW_W-1:0]                  uword,
  output logic [2*BYTE_W-OP_W-1:0]         data_addr,
  output logic                             ram_ce_n,
  output logic                             ram_we_n
);
  import nib_seq_pkg::*;

  localparam int LO_W = BYTE_W - OP_W;
  localparam int PC_W = LO_W + BYTE_W;

  logic [BYTE_W-1:0] ir;
  logic [PC_W-1:0]   pc;
  logic [OP_W-1:0]   op_sel;
  logic [CW_W-1:0]   word;

  assign op_sel = phase ? ir[BYTE_W-1 -: OP_W] : prog_byte[BYTE_W-1 -: OP_W];

  nib_state #(.BYTE_W(BYTE_W), .OP_W(OP_W)) u_state (
    .clk       (clk),
    .rst       (rst),
    .prog_byte (prog_byte),
    .ld_ir     (word[B_IR_LD]),
    .pc_inc    (word[B_PC_INC]),
    .pc_load   (word[B_PC_LD]),
    .phase     (phase),
    .ir        (ir),
    .pc        (pc)
  );

  nib_ucode_rom #(.OP_W(OP_W), .CW_W(CW_W), .UCODE(UCODE)) u_rom (
    .op    (op_sel),
    .phase (phase),
    .carry (flag_carry),
    .zero  (flag_zero),
    .word  (word)
  );

  nib_ram_gate u_gate (
    .clk  (clk),
    .rst  (rst),
    .req  (word[B_RAM_RQ]),
    .wr   (word[B_RAM_WR]),
    .ce_n (ram_ce_n),
    .we_n (ram_we_n)
  );

  assign prog_addr = pc;
  assign uword     = word;
  assign data_addr = {ir[LO_W-1:0], prog_byte};

  AST_ADDR_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (rst)
    phase |-> data_addr[BYTE_W-1:0] == prog_byte); // R6

endmodule

// File: tb/nib_seq_tb.sv
module nib_seq_tb;
  import nib_seq_pkg::*;

  typedef struct packed {
    logic [3:0] op;
    logic [3:0] lo;
    logic [7:0] opnd;
    logic c, z, jmp, accld, req, wr;
    logic [1:0] alu, bus;
  } vec_t;

  // op lo opnd c z | jmp accld req wr alu bus
  localparam vec_t VEC [20] = '{
    '{4'h0, 4'h0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0},
    '{4'h1, 4'h0, 8'h07, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd1},
    '{4'h2, 4'h3, 8'h45, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 2'd2},
    '{4'h3, 4'hA, 8'hBC, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0},
    '{4'h4, 4'h0, 8'h02, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'd1},
    '{4'h5, 4'h1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 2'd2},
    '{4'h6, 4'h0, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 2'd1},
    '{4'h8, 4'h0, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd1},
    '{4'h9, 4'h2, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 2'd2},
    '{4'hA, 4'h0, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd3},
    '{4'hB, 4'h0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0},
    '{4'hC, 4'h2, 8'h34, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0},
    '{4'hC, 4'h7, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0},
    '{4'hD, 4'h1, 8'h80, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0},
    '{4'hD, 4'h1, 8'h80, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0},
    '{4'hE, 4'hF, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0},
    '{4'hE, 4'h3, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0},
    '{4'hF, 4'h0, 8'h10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0},
    '{4'hF, 4'h4, 8'h44, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0},
    '{4'h7, 4'h9, 8'h99, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0}
  };

  function automatic logic [N_WORDS*CW_W-1:0] alt_table();
    logic [N_WORDS*CW_W-1:0] t;
    t = '0;
    for (int i = 0; i < N_WORDS; i++) begin
      logic [IDX_W-1:0] ix;
      ix = IDX_W'(i);
      if (!ix[2])                 t[i*CW_W +: CW_W] = 12'h003;
      else if (ix[IDX_W-1:3] == 0) t[i*CW_W +: CW_W] = 12'h004;
      else                        t[i*CW_W +: CW_W] = 12'h002;
    end
    return t;
  endfunction

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  prog_byte;
  logic        fc, fz;
  logic [11:0] prog_addr, data_addr, a_prog_addr, a_data_addr;
  logic        phase, ram_ce_n, ram_we_n, a_phase, a_ce_n, a_we_n;
  logic [11:0] uword, a_uword;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  nib_seq u_dut (
    .clk(clk), .rst(rst), .prog_byte(prog_byte), .flag_carry(fc), .flag_zero(fz),
    .prog_addr(prog_addr), .phase(phase), .uword(uword), .data_addr(data_addr),
    .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n)
  );

  nib_seq #(.UCODE(alt_table())) u_alt (
    .clk(clk), .rst(rst), .prog_byte(prog_byte), .flag_carry(fc), .flag_zero(fz),
    .prog_addr(a_prog_addr), .phase(a_phase), .uword(a_uword), .data_addr(a_data_addr),
    .ram_ce_n(a_ce_n), .ram_we_n(a_we_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] exp_pc;
    rst = 1'b1; prog_byte = 8'h00; fc = 1'b0; fz = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(prog_addr == 12'h000, "R1 reset pc", prog_addr, 12'h000);
    chk(phase == 1'b0, "R1 reset phase", phase, 0);
    chk(uword == 12'h003, "R3 fetch word op0", uword, 12'h003);
    rst = 1'b0;
    exp_pc = 12'h000;

    // vector walk
    for (int k = 0; k < 20; k++) begin
      prog_byte = {VEC[k].op, VEC[k].lo};
      fc = VEC[k].c;
      fz = VEC[k].z;
      #1;
      chk(phase == 1'b0, "R2 fetch phase", phase, 0);
      chk(prog_addr == exp_pc, "R4/R5 fetch address", prog_addr, exp_pc);
      chk(uword[1:0] == 2'b11, "R4 fetch bits", uword[1:0], 2'b11);
      @(posedge clk);
      #1;
      chk(phase == 1'b1, "R2 execute phase", phase, 1);
      chk(ram_ce_n == 1'b1, "R7 select off while clk high", ram_ce_n, 1);
      @(negedge clk);
      prog_byte = VEC[k].opnd;
      #1;
      chk(prog_addr == exp_pc + 12'd1, "R4 operand address", prog_addr, exp_pc + 12'd1);
      chk(data_addr == {VEC[k].lo, VEC[k].opnd}, "R6 data address", data_addr, {VEC[k].lo, VEC[k].opnd});
      chk({uword[2], uword[1]} == {VEC[k].jmp, ~VEC[k].jmp}, "R9 jump decision",
          {uword[2], uword[1]}, {VEC[k].jmp, ~VEC[k].jmp});
      chk({uword[3], uword[6:5], uword[8:7]} == {VEC[k].accld, VEC[k].alu, VEC[k].bus},
          "R10 data fields", {uword[3], uword[6:5], uword[8:7]}, {VEC[k].accld, VEC[k].alu, VEC[k].bus});
      chk(ram_ce_n == ~VEC[k].req, "R7 select while clk low", ram_ce_n, ~VEC[k].req);
      chk(ram_we_n == ~VEC[k].wr, "R8 write strobe", ram_we_n, ~VEC[k].wr);
      @(posedge clk);
      exp_pc = VEC[k].jmp ? {VEC[k].lo, VEC[k].opnd} : exp_pc + 12'd2;
      @(negedge clk);
    end
    #1;
    chk(prog_addr == exp_pc, "R5 final jump target", prog_addr, exp_pc);

    // reset during execute phase
    prog_byte = 8'h10;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk(prog_addr == 12'h000, "R1 mid reset pc", prog_addr, 0);
    chk(phase == 1'b0, "R1 mid reset phase", phase, 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(prog_addr == 12'h000 && phase == 1'b0, "R1 first fetch addr", prog_addr, 0);
    @(posedge clk);
    #1;
    chk(prog_addr == 12'h001 && phase == 1'b1, "R1 after first fetch", prog_addr, 12'h001);

    // alternative table
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    prog_byte = 8'h05;
    @(posedge clk);
    @(negedge clk);
    prog_byte = 8'h34;
    #1;
    chk(a_uword == 12'h004, "R11 alt execute word", a_uword, 12'h004);
    @(posedge clk);
    #1;
    chk(a_prog_addr == 12'h534, "R11 alt jump", a_prog_addr, 12'h534);
    chk(prog_addr == 12'h002, "R11 default nop", prog_addr, 12'h002);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule